// File: doc/BRIEF.md
# Power-Mode Control and Status Register Bank

This block holds the software-visible controls and flags of a low-power controller. Two byte-wide registers are reached over a simple single-cycle bus with a write strobe, an address and write data, and a combinational read port. The first register selects how the device stops. A write-once enable arms partial power-down, and a mode-select bit then picks the deep stop mode instead of the shallow one. A low-power regulator bit is interlocked against the mode-select bit. The same register carries a sticky flag that reports a wake-up from the deep stop mode, and a write-1 acknowledge that clears it.

The second register tracks the supply warning comparator. Its sticky warning flag latches whenever the live comparator input is high. The flag can only be acknowledged once the condition has gone. An enable bit turns the latched flag into a level interrupt request. A trip-select bit is passed straight out to the analog detector.

Reset is synchronous. While `sys_rst` is high, `rst_kind` tells the block why it is being reset: power-on `2'b00`, low-voltage `2'b01`, deep-stop wake-up `2'b10`, any other cause `2'b11`. The kind decides which fields survive the reset. Each sticky bit and the enable lock is a small named state machine:
- recovery flag: `RCV_NONE` and `RCV_WOKE`. It moves to `RCV_WOKE` on a wake-up reset and back to `RCV_NONE` on an acknowledge or on any other reset.
- enable lock: `EN_OPEN` and `EN_LOCKED`. It moves to `EN_LOCKED` on the first control write and back to `EN_OPEN` on any reset.
- warning: `WRN_CLEAR` and `WRN_LATCHED`. It moves to `WRN_LATCHED` when the live input is seen. It moves back to `WRN_CLEAR` on an acknowledge while the input is low, or on a power-on or other-cause reset.

Top module: `pwr_ctl_regs`

## Requirements
- R1: After a power-on reset with the warning input low, both registers read 0x00 and `warn_irq`, `stop2_sel` and `regulator_lp` are 0.
- R2: The control register has these read-only and write-1 bits:
  - Bit 3 is the recovery flag. It reads 1 after a wake-up reset (`rst_kind` 2'b10), and any other reset kind clears it.
  - Writing 1 to bit 2 clears the flag. Writing 0 to bit 2 leaves it unchanged.
  - Writes to bit 3 itself are ignored.
- R3: Bit 1 of the control register is the enable. The first control-register write after any reset loads it, and every later write leaves it unchanged. Every reset kind clears it and reopens it for writing.
- R4: Bit 0 of the control register is the mode select. A write can set it only if the enable already read 1 before that write. A write of 0 always clears it. `stop2_sel` equals the mode-select bit.
- R5: Bit 4 of the control register is the regulator bit, and it drives `regulator_lp`. Mode select and the regulator bit are never both 1:
  - Mode select cannot be set while the regulator bit reads 1.
  - The regulator bit cannot be set while mode select is 1 after the write.
  - A write setting both bits, made while the regulator bit is 0 and the enable is 1, sets only mode select.
- R6: Bit 3 of the warning register is the warning flag. It is set at the clock edge after `warn_live` is seen high outside reset. It stays set after `warn_live` falls.
- R7: Writing 1 to bit 2 of the warning register clears the flag only if `warn_live` is low in that cycle. If `warn_live` is high in the same cycle as the acknowledge, the flag is set or stays set.
- R8: A low-voltage or wake-up reset keeps the warning flag, interrupt enable (warning bit 0) and trip select (warning bit 1). A power-on or other-cause reset clears all three.
- R9: `warn_irq` is high exactly while the warning flag and the interrupt enable both read 1.
- R10: The two acknowledge bits always read 0. Bits 5 to 7 of the control register and bits 4 to 7 of the warning register read 0 and ignore writes. Addresses other than 0 (control) and 1 (warning) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous reset, active high |
| rst_kind | input | 2 | Cause of the reset in progress: 00 power-on, 01 low-voltage, 10 deep-stop wake, 11 other |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| warn_live | input | 1 | Live supply-warning comparator output |
| stop2_sel | output | 1 | Deep partial power-down stop mode selected |
| regulator_lp | output | 1 | Low-power regulator request |
| warn_trip_sel | output | 1 | Warning trip-level select to the detector |
| warn_irq | output | 1 | Level warning interrupt request |

## Verification
The mode-select logic is driven with every ordering of enable, mode and regulator writes. These runs separate the pre-write enable check from a post-write check, and they show which bit wins a joint write. The sticky flags are tried three ways: against each of the four reset kinds, with acknowledges given while the cause is still present, and with an acknowledge in the same cycle as a new warning. These patterns separate a clear that is conditional from one that is unconditional, and a reset that is kind-aware from a blanket one. Writes of all-ones to reserved positions and reads of unmapped addresses show that no stray bits are stored.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

    // reset cause encodings
    localparam logic [1:0] RK_POWERON = 2'b00;
    localparam logic [1:0] RK_LOWVOLT = 2'b01;
    localparam logic [1:0] RK_WAKE    = 2'b10;
    localparam logic [1:0] RK_OTHER   = 2'b11;

    // control register bit positions
    localparam int CB_MODE = 0;
    localparam int CB_EN   = 1;
    localparam int CB_ACK  = 2;
    localparam int CB_FLAG = 3;
    localparam int CB_LP   = 4;

    // warning register bit positions
    localparam int WB_IE   = 0;
    localparam int WB_TRIP = 1;
    localparam int WB_ACK  = 2;
    localparam int WB_FLAG = 3;

    typedef enum logic {RCV_NONE, RCV_WOKE}       rcv_state_t;
    typedef enum logic {EN_OPEN, EN_LOCKED}       en_state_t;
    typedef enum logic {WRN_CLEAR, WRN_LATCHED}   wrn_state_t;

endpackage

// File: rtl/pwr_recov_flag.sv
module pwr_recov_flag
    import pwr_ctl_pkg::*;
(
    input  logic clk,
    input  logic sys_rst,
    input  logic wake_rst,
    input  logic ack_wr,
    output logic flag
);

    rcv_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (sys_rst) begin
            state_d = wake_rst ? RCV_WOKE : RCV_NONE;
        end else begin
            unique case (state_q)
                RCV_NONE: state_d = RCV_NONE;
                RCV_WOKE: if (ack_wr) state_d = RCV_NONE;
                default:  state_d = RCV_NONE;
            endcase
        end
    end

    always_comb begin
        flag = (state_q == RCV_WOKE);
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_ctl_pkg::*;
(
    input  logic clk,
    input  logic sys_rst,
    input  logic ctl_wr,
    input  logic wr_en_bit,
    input  logic wr_mode_bit,
    input  logic wr_lp_bit,
    output logic en_q,
    output logic mode_q,
    output logic lp_q,
    output logic en_locked
);

    en_state_t lock_q, lock_d;
    logic      en_d, mode_d, lp_d;

    always_ff @(posedge clk) begin
        lock_q <= lock_d;
        en_q   <= en_d;
        mode_q <= mode_d;
        lp_q   <= lp_d;
    end

    // write-once lock of the enable
    always_comb begin
        lock_d = lock_q;
        en_d   = en_q;
        if (sys_rst) begin
            lock_d = EN_OPEN;
            en_d   = 1'b0;
        end else begin
            unique case (lock_q)
                EN_OPEN: begin
                    if (ctl_wr) begin
                        lock_d = EN_LOCKED;
                        en_d   = wr_en_bit;
                    end
                end
                EN_LOCKED: lock_d = EN_LOCKED;
                default:   lock_d = EN_LOCKED;
            endcase
        end
    end

    // mode select and regulator interlock, judged on pre-write state
    always_comb begin
        mode_d = mode_q;
        lp_d   = lp_q;
        if (sys_rst) begin
            mode_d = 1'b0;
            lp_d   = 1'b0;
        end else if (ctl_wr) begin
            mode_d = wr_mode_bit && (mode_q || (en_q && !lp_q));
            lp_d   = wr_lp_bit && !mode_d;
        end
    end

    always_comb begin
        en_locked = (lock_q == EN_LOCKED);
    end

endmodule

// File: rtl/pwr_warn_ctrl.sv
module pwr_warn_ctrl
    import pwr_ctl_pkg::*;
(
    input  logic clk,
    input  logic sys_rst,
    input  logic keep_rst,
    input  logic warn_live,
    input  logic wrn_wr,
    input  logic wr_ie_bit,
    input  logic wr_trip_bit,
    input  logic wr_ack_bit,
    output logic flag,
    output logic ie_q,
    output logic trip_q,
    output logic irq
);

    wrn_state_t state_q, state_d;
    logic       ie_d, trip_d;

    always_ff @(posedge clk) begin
        state_q <= state_d;
        ie_q    <= ie_d;
        trip_q  <= trip_d;
    end

    always_comb begin
        state_d = state_q;
        if (sys_rst) begin
            if (!keep_rst) state_d = WRN_CLEAR;
        end else begin
            unique case (state_q)
                WRN_CLEAR:   if (warn_live) state_d = WRN_LATCHED;
                WRN_LATCHED: if (wrn_wr && wr_ack_bit && !warn_live) state_d = WRN_CLEAR;
                default:     state_d = WRN_CLEAR;
            endcase
        end
    end

    always_comb begin
        ie_d   = ie_q;
        trip_d = trip_q;
        if (sys_rst) begin
            if (!keep_rst) begin
                ie_d   = 1'b0;
                trip_d = 1'b0;
            end
        end else if (wrn_wr) begin
            ie_d   = wr_ie_bit;
            trip_d = wr_trip_bit;
        end
    end

    always_comb begin
        flag = (state_q == WRN_LATCHED);
        irq  = flag && ie_q;
    end

endmodule

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs
    import pwr_ctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter int CTL_ADDR = 0,
    parameter int WRN_ADDR = 1
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic [1:0]        rst_kind,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              warn_live,
    output logic              stop2_sel,
    output logic              regulator_lp,
    output logic              warn_trip_sel,
    output logic              warn_irq
);

    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
    localparam logic [ADDR_W-1:0] WRN_A = ADDR_W'(WRN_ADDR);

    logic ctl_hit, wrn_hit, ctl_wr, wrn_wr;
    logic wake_rst, keep_rst;
    logic recov_flag, en_q, mode_q, lp_q, en_locked;
    logic warn_flag, warn_ie, trip_q;

    always_comb begin
        ctl_hit  = (bus_addr == CTL_A);
        wrn_hit  = (bus_addr == WRN_A);
        ctl_wr   = bus_wr && ctl_hit && !sys_rst;
        wrn_wr   = bus_wr && wrn_hit && !sys_rst;
        wake_rst = (rst_kind == RK_WAKE);
        keep_rst = (rst_kind == RK_LOWVOLT) || (rst_kind == RK_WAKE);
    end

    pwr_recov_flag u_recov (
        .clk      (clk),
        .sys_rst  (sys_rst),
        .wake_rst (wake_rst),
        .ack_wr   (ctl_wr && bus_wdata[CB_ACK]),
        .flag     (recov_flag)
    );

    pwr_mode_ctrl u_mode (
        .clk         (clk),
        .sys_rst     (sys_rst),
        .ctl_wr      (ctl_wr),
        .wr_en_bit   (bus_wdata[CB_EN]),
        .wr_mode_bit (bus_wdata[CB_MODE]),
        .wr_lp_bit   (bus_wdata[CB_LP]),
        .en_q        (en_q),
        .mode_q      (mode_q),
        .lp_q        (lp_q),
        .en_locked   (en_locked)
    );

    pwr_warn_ctrl u_warn (
        .clk         (clk),
        .sys_rst     (sys_rst),
        .keep_rst    (keep_rst),
        .warn_live   (warn_live),
        .wrn_wr      (wrn_wr),
        .wr_ie_bit   (bus_wdata[WB_IE]),
        .wr_trip_bit (bus_wdata[WB_TRIP]),
        .wr_ack_bit  (bus_wdata[WB_ACK]),
        .flag        (warn_flag),
        .ie_q        (warn_ie),
        .trip_q      (trip_q),
        .irq         (warn_irq)
    );

    // read mux: acknowledge and reserved positions stay 0
    always_comb begin
        bus_rdata = '0;
        if (ctl_hit) begin
            bus_rdata[CB_MODE] = mode_q;
            bus_rdata[CB_EN]   = en_q;
            bus_rdata[CB_FLAG] = recov_flag;
            bus_rdata[CB_LP]   = lp_q;
        end else if (wrn_hit) begin
            bus_rdata[WB_IE]   = warn_ie;
            bus_rdata[WB_TRIP] = trip_q;
            bus_rdata[WB_FLAG] = warn_flag;
        end
    end

    always_comb begin
        stop2_sel     = mode_q;
        regulator_lp  = lp_q;
        warn_trip_sel = trip_q;
    end

endmodule

// File: rtl/pwr_ctl_regs_chk.sv
module pwr_ctl_regs_chk
    import pwr_ctl_pkg::*;
(
    input logic       clk,
    input logic       sys_rst,
    input logic [1:0] rst_kind,
    input logic       warn_live,
    input logic       en_q,
    input logic       mode_q,
    input logic       lp_q,
    input logic       en_locked,
    input logic       recov_flag,
    input logic       warn_flag
);

    a_r5_never_both: assert property (@(posedge clk) disable iff (sys_rst)
        !(mode_q && lp_q));

    a_r4_mode_needs_en: assert property (@(posedge clk) disable iff (sys_rst)
        $rose(mode_q) |-> $past(en_q));

    a_r3_lock_holds: assert property (@(posedge clk) disable iff (sys_rst)
        en_locked |=> $stable(en_q));

    a_r6_live_sets: assert property (@(posedge clk) disable iff (sys_rst)
        warn_live |=> warn_flag);

    a_r2_wake_only: assert property (@(posedge clk) disable iff (sys_rst)
        $rose(recov_flag) |-> ($past(sys_rst) && $past(rst_kind) == RK_WAKE));

endmodule

bind pwr_ctl_regs pwr_ctl_regs_chk u_chk (
    .clk        (clk),
    .sys_rst    (sys_rst),
    .rst_kind   (rst_kind),
    .warn_live  (warn_live),
    .en_q       (en_q),
    .mode_q     (mode_q),
    .lp_q       (lp_q),
    .en_locked  (en_locked),
    .recov_flag (recov_flag),
    .warn_flag  (warn_flag)
);

// File: tb/pwr_ctl_regs_test.sv
module pwr_ctl_regs_test;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic [1:0] rst_kind = 2'b00;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       warn_live = 1'b0;
    logic       stop2_sel, regulator_lp, warn_trip_sel, warn_irq;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;
    exp_item_t sb[$];

    always #2 clk = ~clk;

    pwr_ctl_regs uut (
        .clk(clk), .sys_rst(sys_rst), .rst_kind(rst_kind),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .warn_live(warn_live),
        .stop2_sel(stop2_sel), .regulator_lp(regulator_lp),
        .warn_trip_sel(warn_trip_sel), .warn_irq(warn_irq)
    );

    // monitor: samples 1 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.sel)
                    0:       act = bus_rdata;
                    1:       act = {7'd0, warn_irq};
                    2:       act = {7'd0, stop2_sel};
                    default: act = {7'd0, regulator_lp};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    // all driver tasks start and end at a falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        bus_addr = a;
        it.sel = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic pin(input int s, input logic e, input string tag);
        exp_item_t it;
        it.sel = s; it.exp = {7'd0, e}; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] k);
        sys_rst = 1'b1; rst_kind = k;
        @(negedge clk);
        sys_rst = 1'b0; rst_kind = 2'b00;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        sys_rst = 1'b0;
        // R1 power-on state
        rd(0, 8'h00, "R1 ctl after power-on");
        rd(1, 8'h00, "R1 warn after power-on");
        pin(1, 1'b0, "R1 irq low");
        pin(2, 1'b0, "R1 stop2_sel low");
        pin(3, 1'b0, "R1 regulator low");

        // R4 mode needs enable before the write; R3 write-once
        wr(0, 8'h03);
        rd(0, 8'h02, "R4 mode blocked on same write as enable");
        pin(2, 1'b0, "R4 stop2_sel still low");
        wr(0, 8'h00);
        rd(0, 8'h02, "R3 enable clear ignored after lock");
        wr(0, 8'h01);
        rd(0, 8'h03, "R4 mode set with enable");
        pin(2, 1'b1, "R4 stop2_sel high");

        // R5 interlock
        wr(0, 8'h11);
        rd(0, 8'h03, "R5 regulator blocked while mode set");
        wr(0, 8'h00);
        rd(0, 8'h02, "R4 mode cleared by write 0");
        wr(0, 8'h10);
        rd(0, 8'h12, "R5 regulator set alone");
        pin(3, 1'b1, "R5 regulator_lp high");
        wr(0, 8'h11);
        rd(0, 8'h12, "R5 mode blocked while regulator set");
        wr(0, 8'h01);
        rd(0, 8'h02, "R5 mode blocked by old regulator value");
        wr(0, 8'h11);
        rd(0, 8'h03, "R5 joint write sets only mode");
        pin(3, 1'b0, "R5 regulator_lp low");

        // R3 reset reopens, lock at 0
        do_reset(2'b11);
        rd(0, 8'h00, "R3 other reset clears enable");
        wr(0, 8'h00);
        wr(0, 8'h02);
        rd(0, 8'h00, "R3 enable locked at 0");
        wr(0, 8'h01);
        rd(0, 8'h00, "R4 mode blocked with enable 0");

        // R2 recovery flag
        do_reset(2'b10);
        rd(0, 8'h08, "R2 flag after wake reset");
        wr(0, 8'h00);
        rd(0, 8'h08, "R2 write 0 to ack keeps flag");
        wr(0, 8'h08);
        rd(0, 8'h08, "R2 write to flag bit ignored");
        wr(0, 8'h04);
        rd(0, 8'h00, "R2 ack clears flag");
        do_reset(2'b10);
        do_reset(2'b01);
        rd(0, 8'h00, "R2 low-voltage reset clears flag");
        do_reset(2'b10);
        do_reset(2'b00);
        rd(0, 8'h00, "R2 power-on reset clears flag");

        // R6, R7, R9 warning flag
        warn_live = 1'b1;
        step();
        rd(1, 8'h08, "R6 flag set by live warning");
        pin(1, 1'b0, "R9 irq low with ie 0");
        wr(1, 8'h01);
        pin(1, 1'b1, "R9 irq high with ie 1");
        wr(1, 8'h05);
        rd(1, 8'h09, "R7 ack ignored while live");
        warn_live = 1'b0;
        step();
        rd(1, 8'h09, "R6 flag sticky after live falls");
        wr(1, 8'h03);
        rd(1, 8'h0B, "R8 setup ie and trip");

        // R8 reset kinds
        do_reset(2'b01);
        rd(1, 8'h0B, "R8 low-voltage reset keeps warning");
        do_reset(2'b10);
        rd(1, 8'h0B, "R8 wake reset keeps warning");
        rd(0, 8'h08, "R2 wake reset sets flag");
        do_reset(2'b11);
        rd(1, 8'h00, "R8 other reset clears warning");
        warn_live = 1'b1; step(); warn_live = 1'b0;
        wr(1, 8'h03);
        do_reset(2'b00);
        rd(1, 8'h00, "R8 power-on reset clears warning");
        pin(1, 1'b0, "R9 irq low after clear");

        // R7 ack and set-wins
        warn_live = 1'b1; step(); warn_live = 1'b0;
        wr(1, 8'h04);
        rd(1, 8'h00, "R7 ack clears when cause gone");
        warn_live = 1'b1;
        wr(1, 8'h04);
        warn_live = 1'b0;
        rd(1, 8'h08, "R7 set wins over same-cycle ack");

        // R10 reserved and unmapped
        wr(1, 8'hF0);
        rd(1, 8'h08, "R10 warn reserved bits read 0");
        wr(0, 8'hE0);
        rd(0, 8'h00, "R10 ctl reserved bits read 0");
        rd(2, 8'h00, "R10 unmapped address 2");
        rd(3, 8'h00, "R10 unmapped address 3");

        step();
        step();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule